// File: doc/BRIEF.md
# I2C Target Engine with Clock Stretching

This block is the bus-side engine of an I2C target. It watches the SCL and SDA wires through synchronizers and can pull either wire low through a pair of drive-low outputs, which suits an open-drain pad. Each address byte is compared against a 7-bit local address set on an input. On a match the block acknowledges in hardware and then holds SCL low, so that firmware has time to act before the next byte.

Firmware reacts to a single-cycle event pulse that carries a cause code. It can read the last received byte, and it hands over a byte to transmit with a write strobe. That write also ends the clock stretch. A separate release strobe ends a stretch without loading data. Two controls are available: one enables the acknowledge sent for received data bytes, and one selects whether a received byte is stretched after its 8th or after its 9th clock. A status bit reports whether the master acknowledged the last transmitted byte.

Top module: `i2c_tgt_stretch`

## Requirements
- R1: While reset is held and right after it, both drive-low outputs are 0, no event pulses, `ack_seen_o` is 0 and `rd_data_o` is 0.
- R2: Address bytes arrive MSB first. When bits 7..1 of the address byte equal `own_addr_i`, the block drives SDA low for the 9th clock. This happens whatever the value of `ack_en_i`.
- R3: On an address mismatch the block leaves SDA released on the 9th clock, raises no event and does not stretch. It then ignores all traffic until the next START or STOP.
- R4: After a matching address, on the falling edge of the 9th clock the block pulls SCL low and pulses `evt_o` with `evt_cause_o` = 1 (address match).
- R5: Bit 0 of the address byte selects the direction. A value of 0 puts the block in receive mode (the master writes). A value of 1 puts it in transmit mode (the master reads).
- R6: A stretch lasts until a one-cycle pulse on `wr_strobe_i` or on `rel_strobe_i`. Either pulse ends it, and so does a START or STOP.
- R7: In receive mode the byte, taken MSB first, appears on `rd_data_o` after the falling edge of its 8th clock. The block drives ACK (SDA low) on the 9th clock only when `ack_en_i` is 1.
- R8: In receive mode, `wait_at9_i` = 0 stretches and pulses `evt_o` with cause 2 (transfer done) at the falling edge of the 8th clock. `wait_at9_i` = 1 does the same at the falling edge of the 9th clock and not at the 8th.
- R9: In transmit mode, a `wr_strobe_i` during a stretch loads `wr_data_i` and releases SCL. The byte is then shifted out MSB first, and SDA changes only while SCL is low.
- R10: In transmit mode, `ack_seen_o` samples the master's 9th-clock bit on its rising edge (1 = ACK, SDA low). On the 9th falling edge `evt_o` pulses with cause 2. The block then stretches after an ACK. After a NACK it does not stretch and ignores traffic until START or STOP.
- R11: A START or STOP at any point clears the bit counter, releases SDA and SCL and returns the block to address reception. A START also clears `ack_seen_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | SCL wire level |
| sda_i | input | 1 | SDA wire level |
| own_addr_i | input | 7 | Local target address |
| ack_en_i | input | 1 | Acknowledge received data bytes |
| wait_at9_i | input | 1 | Receive stretch point: 0 = after 8th clock, 1 = after 9th |
| wr_strobe_i | input | 1 | Load `wr_data_i` into the shift register and end a stretch |
| wr_data_i | input | 8 | Byte to transmit |
| rel_strobe_i | input | 1 | End a stretch without loading data |
| scl_low_o | output | 1 | Pull SCL low (stretch) |
| sda_low_o | output | 1 | Pull SDA low |
| rd_data_o | output | 8 | Last received byte |
| ack_seen_o | output | 1 | Master acknowledged the last transmitted byte |
| evt_o | output | 1 | One-cycle event pulse |
| evt_cause_o | output | 2 | Event cause: 1 = address match, 2 = transfer done |

## Verification
The address is swept over the local address and every single-bit corruption of it, in both directions. This separates a full 7-bit comparison from a partial one, and the direction bit from the address bits. Received bytes (00, FF, A5, 5A) run under all four settings of the stretch point and of the acknowledge enable. These runs tell the 8th-clock stretch from the 9th-clock stretch, and an ACK from a NACK. Transmitted bytes (A5, 00, FF, 3C) are read back with the master's ACK and then its NACK, to tell a stretching end from a parking end. A START inserted in the middle of an address byte, and a START after an acknowledged read, show that the counter and the status really reset.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
   typedef enum logic [1:0] {
      PH_ADDR = 2'd0,
      PH_RECV = 2'd1,
      PH_SEND = 2'd2,
      PH_PARK = 2'd3
   } phase_e;

   typedef enum logic [1:0] {
      EV_NONE = 2'd0,
      EV_ADDR = 2'd1,
      EV_XFER = 2'd2
   } cause_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
   parameter int LINES  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] async_i,
   output logic [LINES-1:0] sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_tgt_sync: STAGES must be at least 2");
   end
   if (LINES < 1) begin : g_bad_lines
      $error("i2c_tgt_sync: LINES must be at least 1");
   end

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[STAGES-2:0], async_i[g]};
      end
      assign sync_o[g] = chain[STAGES-1];
   end
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s_i,
   input  logic sda_s_i,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s_i;
         sda_q <= sda_s_i;
      end
   end

   // SCL must be high on both samples so a simultaneous change is never a condition
   assign scl_rise_o = scl_s_i & ~scl_q;
   assign scl_fall_o = ~scl_s_i & scl_q;
   assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
   assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
   import i2c_tgt_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s_i,
   input  logic              sda_s_i,
   input  logic              scl_rise_i,
   input  logic              scl_fall_i,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic              ack_en_i,
   input  logic              wait_at9_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              rel_i,
   output logic              scl_low_o,
   output logic              sda_low_o,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              ack_seen_o,
   output logic              evt_o,
   output logic [1:0]        evt_cause_o
);
   localparam int CNT_W = $clog2(DATA_W + 2);
   localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(DATA_W + 1);

   if (ADDR_W != DATA_W - 1) begin : g_bad_addr
      $error("i2c_tgt_engine: ADDR_W must equal DATA_W-1");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("i2c_tgt_engine: DATA_W must be at least 2");
   end

   phase_e            phase;
   cause_e            cause_q;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] rx_sh, tx_sh, rd_q;
   logic              hit_q, dir_q, scl_low, sda_low, ack_seen, evt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_ADDR;
         cause_q  <= EV_NONE;
         cnt      <= '0;
         rx_sh    <= '0;
         tx_sh    <= '0;
         rd_q     <= '0;
         hit_q    <= 1'b0;
         dir_q    <= 1'b0;
         scl_low  <= 1'b0;
         sda_low  <= 1'b0;
         ack_seen <= 1'b0;
         evt_q    <= 1'b0;
      end else begin
         evt_q <= 1'b0;
         if (start_i || stop_i) begin
            phase   <= PH_ADDR;
            cnt     <= '0;
            scl_low <= 1'b0;
            sda_low <= 1'b0;
            if (start_i) ack_seen <= 1'b0;
         end else begin
            // stretch release by firmware
            if (scl_low && (wr_i || rel_i)) begin
               scl_low <= 1'b0;
               if (wr_i) tx_sh <= wr_data_i;
               if (phase == PH_SEND)
                  sda_low <= wr_i ? ~wr_data_i[DATA_W-1] : ~tx_sh[DATA_W-1];
               if (phase == PH_RECV && cnt == LAST_DATA)
                  sda_low <= ack_en_i;
            end
            if (scl_rise_i) begin
               cnt <= cnt + 1'b1;
               if ((phase == PH_ADDR || phase == PH_RECV) && cnt < LAST_DATA)
                  rx_sh <= {rx_sh[DATA_W-2:0], sda_s_i};
               if (phase == PH_SEND && cnt == LAST_DATA)
                  ack_seen <= ~sda_s_i;
            end
            if (scl_fall_i) begin
               unique case (phase)
                  PH_ADDR: begin
                     if (cnt == LAST_DATA) begin
                        hit_q   <= (rx_sh[DATA_W-1:1] == own_addr_i);
                        dir_q   <= rx_sh[0];
                        sda_low <= (rx_sh[DATA_W-1:1] == own_addr_i);
                     end else if (cnt == ACK_SLOT) begin
                        cnt     <= '0;
                        sda_low <= 1'b0;
                        if (hit_q) begin
                           scl_low <= 1'b1;
                           evt_q   <= 1'b1;
                           cause_q <= EV_ADDR;
                           phase   <= dir_q ? PH_SEND : PH_RECV;
                        end else begin
                           phase <= PH_PARK;
                        end
                     end
                  end
                  PH_RECV: begin
                     if (cnt == LAST_DATA) begin
                        rd_q    <= rx_sh;
                        sda_low <= ack_en_i;
                        if (!wait_at9_i) begin
                           scl_low <= 1'b1;
                           evt_q   <= 1'b1;
                           cause_q <= EV_XFER;
                        end
                     end else if (cnt == ACK_SLOT) begin
                        cnt     <= '0;
                        sda_low <= 1'b0;
                        if (wait_at9_i) begin
                           scl_low <= 1'b1;
                           evt_q   <= 1'b1;
                           cause_q <= EV_XFER;
                        end
                     end
                  end
                  PH_SEND: begin
                     if (cnt != '0 && cnt < LAST_DATA) begin
                        tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
                        sda_low <= ~tx_sh[DATA_W-2];
                     end else if (cnt == LAST_DATA) begin
                        sda_low <= 1'b0;
                     end else if (cnt == ACK_SLOT) begin
                        cnt     <= '0;
                        evt_q   <= 1'b1;
                        cause_q <= EV_XFER;
                        if (ack_seen) scl_low <= 1'b1;
                        else          phase   <= PH_PARK;
                     end
                  end
                  PH_PARK: begin
                     if (cnt == ACK_SLOT) cnt <= '0;
                  end
               endcase
            end
         end
      end
   end

   assign scl_low_o   = scl_low;
   assign sda_low_o   = sda_low;
   assign rd_data_o   = rd_q;
   assign ack_seen_o  = ack_seen;
   assign evt_o       = evt_q;
   assign evt_cause_o = cause_q;

   // R3 / R10: a parked engine never touches the bus
   assert_park_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_PARK) |-> (!scl_low && !sda_low));

   // R4 / R8: every new stretch comes with an event in the same cycle
   assert_stretch_evt_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_low) |-> evt_q);

   // R6: a stretch holds until a strobe or a bus condition
   assert_stretch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_low && !(wr_i || rel_i || start_i || stop_i)) |=> scl_low);

   // R9: SDA drive changes only while SCL is low, bus conditions aside
   assert_sda_when_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_low) && !$past(start_i || stop_i)) |-> !$past(scl_s_i));

   // R11: a bus condition releases everything and clears the count
   assert_cond_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i || stop_i) |=> (cnt == '0 && !scl_low && !sda_low));
endmodule

// File: rtl/i2c_tgt_stretch.sv
module i2c_tgt_stretch #(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic              ack_en_i,
   input  logic              wait_at9_i,
   input  logic              wr_strobe_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              rel_strobe_i,
   output logic              scl_low_o,
   output logic              sda_low_o,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              ack_seen_o,
   output logic              evt_o,
   output logic [1:0]        evt_cause_o
);
   logic [1:0] sync_w;
   logic       scl_rise, scl_fall, start_w, stop_w;

   i2c_tgt_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({scl_i, sda_i}),
      .sync_o  (sync_w)
   );

   i2c_tgt_cond u_cond (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_s_i    (sync_w[1]),
      .sda_s_i    (sync_w[0]),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (start_w),
      .stop_o     (stop_w)
   );

   i2c_tgt_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_eng (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_s_i     (sync_w[1]),
      .sda_s_i     (sync_w[0]),
      .scl_rise_i  (scl_rise),
      .scl_fall_i  (scl_fall),
      .start_i     (start_w),
      .stop_i      (stop_w),
      .own_addr_i  (own_addr_i),
      .ack_en_i    (ack_en_i),
      .wait_at9_i  (wait_at9_i),
      .wr_i        (wr_strobe_i),
      .wr_data_i   (wr_data_i),
      .rel_i       (rel_strobe_i),
      .scl_low_o   (scl_low_o),
      .sda_low_o   (sda_low_o),
      .rd_data_o   (rd_data_o),
      .ack_seen_o  (ack_seen_o),
      .evt_o       (evt_o),
      .evt_cause_o (evt_cause_o)
   );
endmodule

// File: tb/i2c_tgt_stretch_tb.sv
module i2c_tgt_stretch_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int HQ         = 40;
   localparam int WD_CYCLES  = 190000;
   localparam logic [6:0] OWN = 7'h2A;

   logic clk = 1'b0, rst_n = 1'b0;
   logic m_scl_low = 1'b0, m_sda_low = 1'b0;
   logic ack_en = 1'b1, wait_at9 = 1'b1, wr_s = 1'b0, rel_s = 1'b0;
   logic [7:0] wr_d = 8'h00;
   logic scl_low_o, sda_low_o, ack_seen_o, evt_o;
   logic [7:0] rd_data_o;
   logic [1:0] evt_cause_o;
   wire scl_w = ~(m_scl_low | scl_low_o);
   wire sda_w = ~(m_sda_low | sda_low_o);

   int n_chk = 0, n_fail = 0, evt_cnt = 0, last_cause = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_tgt_stretch dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_w), .sda_i(sda_w),
      .own_addr_i(OWN), .ack_en_i(ack_en), .wait_at9_i(wait_at9),
      .wr_strobe_i(wr_s), .wr_data_i(wr_d), .rel_strobe_i(rel_s),
      .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .rd_data_o(rd_data_o),
      .ack_seen_o(ack_seen_o), .evt_o(evt_o), .evt_cause_o(evt_cause_o)
   );

   always @(negedge clk) if (rst_n && evt_o) begin
      evt_cnt++;
      last_cause = int'(evt_cause_o);
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clk_bit(input logic one, output logic seen);
      m_sda_low = ~one;
      idle(HQ);
      m_scl_low = 1'b0;
      wait (scl_w === 1'b1);
      idle(HQ/2);
      seen = sda_w;
      idle(HQ/2);
      m_scl_low = 1'b1;
      idle(12);
   endtask

   task automatic bus_start();
      m_sda_low = 1'b0;
      idle(HQ);
      m_scl_low = 1'b0;
      wait (scl_w === 1'b1);
      idle(HQ);
      m_sda_low = 1'b1;
      idle(HQ);
      m_scl_low = 1'b1;
      idle(12);
   endtask

   task automatic bus_stop();
      m_sda_low = 1'b1;
      idle(HQ);
      m_scl_low = 1'b0;
      wait (scl_w === 1'b1);
      idle(HQ);
      m_sda_low = 1'b0;
      idle(HQ);
   endtask

   task automatic send8(input logic [7:0] b);
      logic s;
      for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
   endtask

   task automatic recv8(output logic [7:0] v);
      logic s;
      v = '0;
      for (int i = 0; i < 8; i++) begin
         clk_bit(1'b1, s);
         v = {v[6:0], s};
      end
   endtask

   task automatic pulse_rel();
      @(negedge clk) rel_s = 1'b1;
      @(negedge clk) rel_s = 1'b0;
      idle(4);
   endtask

   task automatic pulse_wr(input logic [7:0] d);
      @(negedge clk) begin wr_s = 1'b1; wr_d = d; end
      @(negedge clk) wr_s = 1'b0;
      idle(4);
   endtask

   task automatic addr_phase(input logic [6:0] a, input logic rw, output logic ack);
      logic s;
      send8({a, rw});
      clk_bit(1'b1, s);
      ack = s;
   endtask

   logic [7:0] rx_pat [4] = '{8'h00, 8'hFF, 8'hA5, 8'h5A};
   logic [7:0] tx_pat [4] = '{8'hA5, 8'h00, 8'hFF, 8'h3C};

   initial begin
      logic a, hit;
      logic [6:0] addr;
      logic [7:0] v;
      int e0;
      idle(3);
      chk("R1", "scl_low in reset", int'(scl_low_o), 0);
      chk("R1", "sda_low in reset", int'(sda_low_o), 0);
      rst_n = 1'b1;
      idle(HQ);
      chk("R1", "scl_low after reset", int'(scl_low_o), 0);
      chk("R1", "sda_low after reset", int'(sda_low_o), 0);
      chk("R1", "ack_seen after reset", int'(ack_seen_o), 0);
      chk("R1", "rd_data after reset", int'(rd_data_o), 0);
      chk("R1", "no event after reset", evt_cnt, 0);

      // Address sweep: exact local address and every single-bit corruption, both directions
      for (int rw = 0; rw < 2; rw++) begin
         for (int k = -1; k < 7; k++) begin
            addr = (k < 0) ? OWN : (OWN ^ (7'd1 << k));
            hit  = (k < 0);
            bus_start();
            e0 = evt_cnt;
            addr_phase(addr, rw[0], a);
            chk(hit ? "R2" : "R3", "address ack bit", int'(a), int'(!hit));
            chk(hit ? "R4" : "R3", "address event count", evt_cnt - e0, int'(hit));
            chk(hit ? "R4" : "R3", "stretch after address", int'(scl_low_o), int'(hit));
            if (hit) begin
               chk("R4", "address event cause", last_cause, 1);
               if (rw == 1) pulse_wr(8'hFF); else pulse_rel();
            end else begin
               send8(8'h00);
               clk_bit(1'b1, a);
               chk("R3", "parked target leaves data unacked", int'(a), 1);
               chk("R3", "parked target raises no event", evt_cnt - e0, 0);
               chk("R3", "parked target never stretches", int'(scl_low_o), 0);
            end
            bus_stop();
         end
      end

      // Master writes: every stretch point and ack enable combination
      for (int cfg = 0; cfg < 4; cfg++) begin
         wait_at9 = cfg[0];
         ack_en   = cfg[1];
         bus_start();
         addr_phase(OWN, 1'b0, a);
         chk("R2", "address acked with ack_en any", int'(a), 0);
         chk("R4", "address cause", last_cause, 1);
         pulse_rel();
         for (int i = 0; i < 4; i++) begin
            e0 = evt_cnt;
            send8(rx_pat[i]);
            chk(i == 0 ? "R5" : "R7", "received byte", int'(rd_data_o), int'(rx_pat[i]));
            chk("R8", "stretch at 8th fall", int'(scl_low_o), int'(!wait_at9));
            chk("R8", "event at 8th fall", evt_cnt - e0, int'(!wait_at9));
            if (!wait_at9) begin
               chk("R8", "cause at 8th fall", last_cause, 2);
               if (i[0]) pulse_wr(8'h00); else pulse_rel();
               chk("R6", "strobe ends stretch", int'(scl_low_o), 0);
            end
            clk_bit(1'b1, a);
            chk("R7", "data ack bit", int'(a), int'(!ack_en));
            chk("R8", "stretch at 9th fall", int'(scl_low_o), int'(wait_at9));
            chk("R8", "event total per byte", evt_cnt - e0, 1);
            if (wait_at9) begin
               chk("R8", "cause at 9th fall", last_cause, 2);
               if (i[0]) pulse_wr(8'h00); else pulse_rel();
               chk("R6", "strobe ends stretch", int'(scl_low_o), 0);
            end
         end
         bus_stop();
      end

      // Master reads: ACK on the first bytes, NACK on the last
      wait_at9 = 1'b1;
      ack_en   = 1'b1;
      bus_start();
      addr_phase(OWN, 1'b1, a);
      chk("R2", "read address acked", int'(a), 0);
      chk("R4", "read address stretch", int'(scl_low_o), 1);
      for (int i = 0; i < 4; i++) begin
         pulse_wr(tx_pat[i]);
         chk("R6", "write ends stretch", int'(scl_low_o), 0);
         e0 = evt_cnt;
         recv8(v);
         chk(i == 0 ? "R5" : "R9", "transmitted byte", int'(v), int'(tx_pat[i]));
         clk_bit(i == 3, a);
         chk("R10", "ack_seen", int'(ack_seen_o), int'(i != 3));
         chk("R10", "transfer event", evt_cnt - e0, 1);
         chk("R10", "transfer cause", last_cause, 2);
         chk("R10", "stretch only after ACK", int'(scl_low_o), int'(i != 3));
      end
      e0 = evt_cnt;
      recv8(v);
      chk("R10", "bus released after NACK", int'(v), 8'hFF);
      chk("R10", "no event after NACK", evt_cnt - e0, 0);
      bus_stop();

      // START inside an address byte restarts address reception
      bus_start();
      for (int i = 6; i >= 3; i--) clk_bit(OWN[i], a);
      bus_start();
      e0 = evt_cnt;
      addr_phase(OWN, 1'b0, a);
      chk("R11", "address after mid-byte START acked", int'(a), 0);
      chk("R11", "one event after mid-byte START", evt_cnt - e0, 1);
      pulse_rel();
      bus_stop();

      // START clears ack_seen after an acknowledged read
      bus_start();
      addr_phase(OWN, 1'b1, a);
      pulse_wr(8'h7E);
      recv8(v);
      clk_bit(1'b0, a);
      chk("R10", "ack_seen before START", int'(ack_seen_o), 1);
      pulse_wr(8'hFF);
      bus_start();
      chk("R11", "START clears ack_seen", int'(ack_seen_o), 0);
      chk("R11", "START leaves SCL free", int'(scl_low_o), 0);
      chk("R11", "START leaves SDA free", int'(sda_low_o), 0);
      bus_stop();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R1-chain: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule